// File: doc/BRIEF.md
# Rational Resize Phase Sequencer

This block turns a scaling ratio, given as an output count `num` over an input count `denom`, into the list of entries for one axis of a resize coefficient table. Each entry belongs to one output phase. It holds an interpolation weight between 0 and 512, where 512 selects the nearer source pixel completely. It also holds a source-advance offset, which is the number of input pixels to step past before the next phase. A controller pulses `start` with the ratio, and then writes each entry into the table when `entryValid` is high. `last` marks the final entry.

Three recurrences are supported. When `denom` exceeds `num` the block shrinks the image, and a phase accumulator walks modulo twice the numerator. When `denom` is 1 it enlarges by an integer factor, and every phase is nearest-neighbour. In every other case it enlarges by a fraction, and a single accumulator wraps at `num`. All divisions go through one shared multi-cycle restoring divider. Building the ratio and evaluating the filter kernel belong to other blocks.

Top module: `rational_phase_seq`

## Requirements
- R1: After reset `busy`, `entryValid` and `rejected` are low. No entry is emitted while `busy` is low.
- R2: A `start` in idle is rejected when `num` is 0, `denom` is 0 or `num` exceeds 31. In that case `rejected` is high in the same cycle as `start`, `busy` stays low and no entry is emitted.
- R3: A `start` with `num` equal to `denom` is not rejected, emits no entries and leaves `busy` low.
- R4: An accepted ratio emits exactly `num` entries. `last` is high only on the final one, and `busy` falls in the cycle after it.
- R5: When `denom > num`, the shrink walk is used. `a` starts at `denom`. For each entry, first set `a = num + (a-num) mod 2num` and output weight `512 - 512(a-num) div 2num`. Then set `a += 2denom` and output offset `(a-num) div 2num`.
- R6: When `1 < denom < num`, `a` starts at 0. Each entry outputs weight `512 - 512a div num`. Then `a += denom`, the offset is 1 if `a >= num` and 0 otherwise, and `a` is reduced by `num` when the offset is 1. Every emitted weight lies in 1..512.
- R7: When `denom` is 1 and `num > 1`, every entry has weight 512. Its offset is 1 on the final entry and 0 on all others.
- R8: A `start` while `busy` is high is ignored, and the running sequence completes with its own ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new table sequence (taken only while idle) |
| num | input | NUM_W (6) | Ratio numerator, the number of output phases |
| denom | input | DEN_W (8) | Ratio denominator |
| entryValid | output | 1 | One table entry is presented this cycle |
| weight | output | 10 | Interpolation weight, 0..512 |
| offset | output | DEN_W (8) | Source-advance offset for this entry |
| last | output | 1 | Marks the final entry of the sequence |
| busy | output | 1 | A sequence is in progress |
| rejected | output | 1 | The ratio offered with `start` is out of range |

## Verification
The assertions assume two things about the inputs. First, `denom` is at least as wide as the internal phase index. Second, a ratio stays captured from its accepted `start` until `busy` falls, so the entry-count and integer-mode checks can rely on values latched at acceptance. The stimulus offers `start` for one cycle and only from idle, except in the R8 case. That case deliberately pulses a second ratio mid-run, and the latched copy is not updated then. The sweep covers every numerator from 1 to 10 against every denominator from 1 to 12. It adds the edge ratios at numerator 31, which is the largest table, together with the out-of-range and zero operands.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

  localparam int WGT_W       = 10;
  localparam int WEIGHT_FULL = 512;

  typedef enum logic [1:0] {
    MODE_DOWN = 2'd0,
    MODE_INT  = 2'd1,
    MODE_UP   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SRC_PHASE0 = 2'd0,
    SRC_WEIGHT = 2'd1,
    SRC_STEP   = 2'd2
  } div_src_e;

  typedef struct packed {
    logic     loadCfg;
    logic     divGo;
    div_src_e divSrc;
    logic     intEntry;
    logic     intLast;
  } ctrl_strobe_t;

endpackage

// File: rtl/phase_div.sv
// Restoring divider: one quotient bit per cycle, DVD_W cycles per division.
module phase_div #(
  parameter int DVD_W = 15,
  parameter int DSR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient,
  output logic [DSR_W-1:0] remainder
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] dvdR;
  logic [DSR_W-1:0] dsrR, partR;
  logic [CNT_W-1:0] cntR;
  logic             runR, doneR;
  logic [DSR_W:0]   shifted;
  logic [DSR_W+1:0] diff;
  logic             fits;

  always_comb begin
    shifted = {partR, dvdR[DVD_W-1]};
    diff    = {1'b0, shifted} - {2'b00, dsrR};
    fits    = ~diff[DSR_W+1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvdR  <= '0;
      dsrR  <= '0;
      partR <= '0;
      cntR  <= '0;
      runR  <= 1'b0;
      doneR <= 1'b0;
    end else if (go) begin
      dvdR  <= dividend;
      dsrR  <= divisor;
      partR <= '0;
      cntR  <= CNT_W'(DVD_W);
      runR  <= 1'b1;
      doneR <= 1'b0;
    end else if (runR) begin
      dvdR  <= {dvdR[DVD_W-2:0], fits};
      partR <= fits ? diff[DSR_W-1:0] : shifted[DSR_W-1:0];
      cntR  <= cntR - 1'b1;
      runR  <= (cntR != CNT_W'(1));
      doneR <= (cntR == CNT_W'(1));
    end else begin
      doneR <= 1'b0;
    end
  end

  assign done      = doneR;
  assign quotient  = dvdR;
  assign remainder = partR;
endmodule

// File: rtl/phase_seq_dp.sv
// Datapath: ratio registers, phase accumulator, divider operand selection.
module phase_seq_dp
  import phase_seq_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int DEN_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strobe,
  input  logic [IDX_W-1:0]     num,
  input  logic [DEN_W-1:0]     denom,
  output mode_e                mode,
  output logic                 divDone,
  output logic [IDX_W-1:0]     numReg,
  output logic [WGT_W-1:0]     weight,
  output logic [DEN_W-1:0]     offset
);
  localparam int DSR_W  = IDX_W + 1;
  localparam int WDVD_W = 9 + DSR_W;
  localparam int SDVD_W = DEN_W + 2;
  localparam int DVD_W  = (WDVD_W > SDVD_W) ? WDVD_W : SDVD_W;

  logic [IDX_W-1:0] numR;
  logic [DEN_W-1:0] denR;
  logic [DSR_W-1:0] accR;
  logic [WGT_W-1:0] weightR;
  logic [DEN_W-1:0] offsetR;
  div_src_e         srcR;

  logic [DVD_W-1:0] dividend, quotient;
  logic [DSR_W-1:0] divisor, remainder, twoNum, upNext;
  logic             upWrap;

  always_comb begin
    if (denR > DEN_W'(numR))            mode = MODE_DOWN;
    else if (denR == DEN_W'(1))         mode = MODE_INT;
    else                                mode = MODE_UP;
    twoNum = {numR, 1'b0};
    upNext = accR + DSR_W'(denR);
    upWrap = (upNext >= DSR_W'(numR));
    unique case (strobe.divSrc)
      SRC_PHASE0: begin
        dividend = DVD_W'(denR) - DVD_W'(numR);
        divisor  = twoNum;
      end
      SRC_WEIGHT: begin
        dividend = DVD_W'({accR, 9'b0});
        divisor  = (mode == MODE_DOWN) ? twoNum : DSR_W'(numR);
      end
      default: begin
        dividend = DVD_W'(accR) + DVD_W'({denR, 1'b0});
        divisor  = twoNum;
      end
    endcase
  end

  phase_div #(.DVD_W(DVD_W), .DSR_W(DSR_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strobe.divGo),
    .dividend (dividend),
    .divisor  (divisor),
    .done     (divDone),
    .quotient (quotient),
    .remainder(remainder)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numR    <= '0;
      denR    <= '0;
      accR    <= '0;
      weightR <= '0;
      offsetR <= '0;
      srcR    <= SRC_PHASE0;
    end else begin
      if (strobe.loadCfg) begin
        numR <= num;
        denR <= denom;
        accR <= '0;
      end
      if (strobe.divGo) srcR <= strobe.divSrc;
      if (strobe.intEntry) begin
        weightR <= WGT_W'(WEIGHT_FULL);
        offsetR <= DEN_W'(strobe.intLast);
      end
      if (divDone) begin
        unique case (srcR)
          SRC_PHASE0: accR <= remainder;
          SRC_WEIGHT: begin
            weightR <= WGT_W'(WEIGHT_FULL) - quotient[WGT_W-1:0];
            if (mode == MODE_UP) begin
              offsetR <= DEN_W'(upWrap);
              accR    <= upWrap ? (upNext - DSR_W'(numR)) : upNext;
            end
          end
          default: begin
            offsetR <= quotient[DEN_W-1:0];
            accR    <= remainder;
          end
        endcase
      end
    end
  end

  assign numReg = numR;
  assign weight = weightR;
  assign offset = offsetR;
endmodule

// File: rtl/phase_seq_ctrl.sv
// Control: ratio screening, mode-dependent step order, entry counting.
module phase_seq_ctrl
  import phase_seq_pkg::*;
#(
  parameter int NUM_W       = 6,
  parameter int DEN_W       = 8,
  parameter int MAX_ENTRIES = 31,
  parameter int IDX_W       = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NUM_W-1:0]   num,
  input  logic [DEN_W-1:0]   denom,
  input  mode_e              mode,
  input  logic               divDone,
  input  logic [IDX_W-1:0]   numReg,
  output ctrl_strobe_t       strobe,
  output logic               entryValid,
  output logic               last,
  output logic               busy,
  output logic               rejected
);
  typedef enum logic [3:0] {
    S_IDLE, S_PREP, S_INIT_WAIT, S_W_GO, S_W_WAIT,
    S_O_GO, S_O_WAIT, S_INT, S_EMIT
  } state_e;

  state_e           stateR, stateNext;
  logic [IDX_W-1:0] idxR;
  logic             cfgBad, oneToOne, accept, lastEntry;

  always_comb begin
    cfgBad    = (num == '0) || (denom == '0) || (num > NUM_W'(MAX_ENTRIES));
    oneToOne  = (DEN_W'(num) == denom);
    accept    = (stateR == S_IDLE) && start && !cfgBad && !oneToOne;
    rejected  = (stateR == S_IDLE) && start && cfgBad;
    lastEntry = (idxR == numReg - IDX_W'(1));
    busy      = (stateR != S_IDLE);
    entryValid = (stateR == S_EMIT);
    last      = (stateR == S_EMIT) && lastEntry;

    strobe    = '0;
    strobe.divSrc = SRC_WEIGHT;
    stateNext = stateR;
    unique case (stateR)
      S_IDLE: if (accept) begin
        strobe.loadCfg = 1'b1;
        stateNext = S_PREP;
      end
      S_PREP: begin
        if (mode == MODE_DOWN) begin
          strobe.divGo  = 1'b1;
          strobe.divSrc = SRC_PHASE0;
          stateNext = S_INIT_WAIT;
        end else if (mode == MODE_INT) stateNext = S_INT;
        else stateNext = S_W_GO;
      end
      S_INIT_WAIT: if (divDone) stateNext = S_W_GO;
      S_W_GO: begin
        strobe.divGo  = 1'b1;
        strobe.divSrc = SRC_WEIGHT;
        stateNext = S_W_WAIT;
      end
      S_W_WAIT: if (divDone) stateNext = (mode == MODE_DOWN) ? S_O_GO : S_EMIT;
      S_O_GO: begin
        strobe.divGo  = 1'b1;
        strobe.divSrc = SRC_STEP;
        stateNext = S_O_WAIT;
      end
      S_O_WAIT: if (divDone) stateNext = S_EMIT;
      S_INT: begin
        strobe.intEntry = 1'b1;
        strobe.intLast  = lastEntry;
        stateNext = S_EMIT;
      end
      S_EMIT: begin
        if (lastEntry)              stateNext = S_IDLE;
        else if (mode == MODE_INT)  stateNext = S_INT;
        else                        stateNext = S_W_GO;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= S_IDLE;
      idxR   <= '0;
    end else begin
      stateR <= stateNext;
      if (accept)                         idxR <= '0;
      else if (stateR == S_EMIT && !lastEntry) idxR <= idxR + 1'b1;
    end
  end
endmodule

// File: rtl/rational_phase_seq.sv
module rational_phase_seq
  import phase_seq_pkg::*;
#(
  parameter int NUM_W       = 6,
  parameter int DEN_W       = 8,
  parameter int MAX_ENTRIES = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] denom,
  output logic             entryValid,
  output logic [9:0]       weight,
  output logic [DEN_W-1:0] offset,
  output logic             last,
  output logic             busy,
  output logic             rejected
);
  localparam int IDX_W = $clog2(MAX_ENTRIES + 1);

  ctrl_strobe_t     strobe;
  mode_e            mode;
  logic             divDone;
  logic [IDX_W-1:0] numReg;

  phase_seq_ctrl #(
    .NUM_W(NUM_W), .DEN_W(DEN_W), .MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .num       (num),
    .denom     (denom),
    .mode      (mode),
    .divDone   (divDone),
    .numReg    (numReg),
    .strobe    (strobe),
    .entryValid(entryValid),
    .last      (last),
    .busy      (busy),
    .rejected  (rejected)
  );

  phase_seq_dp #(.IDX_W(IDX_W), .DEN_W(DEN_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .num    (num[IDX_W-1:0]),
    .denom  (denom),
    .mode   (mode),
    .divDone(divDone),
    .numReg (numReg),
    .weight (weight),
    .offset (offset)
  );
endmodule

// File: rtl/phase_seq_checker.sv
module phase_seq_checker #(
  parameter int NUM_W = 6,
  parameter int DEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [NUM_W-1:0] num,
  input logic [DEN_W-1:0] denom,
  input logic             entryValid,
  input logic [9:0]       weight,
  input logic             last,
  input logic             busy,
  input logic             rejected
);
  logic [NUM_W-1:0] savedNum, entCnt;
  logic [DEN_W-1:0] savedDen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedNum <= '0;
      savedDen <= '0;
      entCnt   <= '0;
    end else if (!busy && start && !rejected) begin
      savedNum <= num;
      savedDen <= denom;
      entCnt   <= '0;
    end else if (entryValid) begin
      entCnt <= entCnt + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !entryValid);
  p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    rejected |=> !busy);
  p_last_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && last) |-> (entCnt == savedNum - NUM_W'(1)));
  p_last_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && last) |=> !busy);
  p_weight_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (weight >= 10'd1 && weight <= 10'd512));
  p_int_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && savedDen == DEN_W'(1)) |-> (weight == 10'd512));
endmodule

bind rational_phase_seq phase_seq_checker #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .num       (num),
  .denom     (denom),
  .entryValid(entryValid),
  .weight    (weight),
  .last      (last),
  .busy      (busy),
  .rejected  (rejected)
);

// File: tb/tb_rational_phase_seq.sv
module tb_rational_phase_seq;
  localparam int NUM_W = 6;
  localparam int DEN_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN, start;
  logic [NUM_W-1:0] num;
  logic [DEN_W-1:0] denom;
  logic             entryValid, last, busy, rejected;
  logic [9:0]       weight;
  logic [DEN_W-1:0] offset;

  rational_phase_seq #(.NUM_W(NUM_W), .DEN_W(DEN_W), .MAX_ENTRIES(31)) dut (
    .clk(clk), .rstN(rstN), .start(start), .num(num), .denom(denom),
    .entryValid(entryValid), .weight(weight), .offset(offset), .last(last),
    .busy(busy), .rejected(rejected)
  );

  int tests = 0;
  int fails = 0;
  int gotN  = 0;
  int gotW[64], gotO[64], gotL[64];
  int expN;
  int expW[64], expO[64];
  bit expRej;

  always @(negedge clk) begin
    if (rstN && entryValid) begin
      if (gotN < 64) begin
        gotW[gotN] = int'(weight);
        gotO[gotN] = int'(offset);
        gotL[gotN] = int'(last);
      end
      gotN = gotN + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected table from the requirement formulas.
  task automatic model(input int n, input int d);
    int acc;
    expRej = (n == 0) || (d == 0) || (n > 31);
    expN = 0;
    if (expRej || n == d) return;
    expN = n;
    if (d > n) begin
      acc = d;
      for (int i = 0; i < n; i++) begin
        acc = n + (acc - n) % (2 * n);
        expW[i] = 512 - (512 * (acc - n)) / (2 * n);
        acc = acc + 2 * d;
        expO[i] = ((acc - n) / (2 * n)) & 255;
      end
    end else if (d == 1) begin
      for (int i = 0; i < n; i++) begin
        expW[i] = 512;
        expO[i] = (i == n - 1) ? 1 : 0;
      end
    end else begin
      acc = 0;
      for (int i = 0; i < n; i++) begin
        expW[i] = 512 - (512 * acc) / n;
        acc = acc + d;
        expO[i] = (acc >= n) ? 1 : 0;
        if (acc >= n) acc = acc - n;
      end
    end
  endtask

  task automatic run(input int n, input int d, input bit midStart, input string tag);
    int k;
    model(n, d);
    @(negedge clk);
    gotN  = 0;
    num   = NUM_W'(n);
    denom = DEN_W'(d);
    start = 1'b1;
    #2;
    chk(rejected == expRej, "R2", int'(rejected), int'(expRej));
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R8", int'(busy), 1);
      num   = NUM_W'(3);
      denom = DEN_W'(7);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (2) @(negedge clk);
    k = 0;
    while (busy && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(!busy, tag, int'(busy), 0);
    chk(gotN == expN, "R4", gotN, expN);
    for (int i = 0; i < expN && i < gotN && i < 64; i++) begin
      chk(gotW[i] == expW[i], tag, gotW[i], expW[i]);
      chk(gotO[i] == expO[i], tag, gotO[i], expO[i]);
      chk(gotL[i] == ((i == expN - 1) ? 1 : 0), "R4", gotL[i], (i == expN - 1) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN  = 1'b0;
    start = 1'b0;
    num   = '0;
    denom = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(entryValid == 1'b0, "R1", int'(entryValid), 0);
    chk(rejected == 1'b0, "R1", int'(rejected), 0);

    // R2: out-of-range and zero operands
    run(32, 5, 1'b0, "R2");
    run(63, 200, 1'b0, "R2");
    run(0, 4, 1'b0, "R2");
    run(5, 0, 1'b0, "R2");

    // R3: unity ratio
    run(1, 1, 1'b0, "R3");
    run(7, 7, 1'b0, "R3");

    // Sweep: R5 shrink, R7 integer enlarge, R6 fractional enlarge
    for (int n = 1; n <= 10; n++) begin
      for (int d = 1; d <= 12; d++) begin
        if (d > n)       run(n, d, 1'b0, "R5");
        else if (d == 1) run(n, d, 1'b0, "R7");
        else             run(n, d, 1'b0, "R6");
      end
    end

    // Largest table edges
    run(31, 32, 1'b0, "R5");
    run(31, 255, 1'b0, "R5");
    run(31, 1, 1'b0, "R7");
    run(31, 2, 1'b0, "R6");
    run(31, 30, 1'b0, "R6");

    // R8: start pulsed mid-run is ignored
    run(9, 4, 1'b1, "R8");
    run(5, 13, 1'b1, "R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule